// File: doc/BRIEF.md
# Supply-Change CPU Stall Sequencer

This block holds an 8-bit control register and a small sequencer that halts the CPU clock enable while the core supply level changes. Software selects a stall length code and an optional deep-sleep voltage drop. A supply-change request switches the supply-level select at once. The CPU clock enable then stays low for the coded number of slow-clock periods, so the regulator can settle before the core runs again. The peripheral clock enable is not touched by any of this.

When the drop option is on, entering a deep low-power mode moves the supply select to the lowest level and records the level that was in use. On wake-up the recorded level is put back, and the CPU stays held for the programmed stall length. The slow clock reaches the block as a one-cycle tick in the fast clock domain. Stall time is the code's period count divided by the slow-clock rate. At 32.768 kHz, 8 periods is about 244 µs and 512 periods is about 15.6 ms. A rise from 1.1 V to 1.8 V needs at least 500 µs, so code 011 or higher. A rise from 1.1 V to 1.3 V needs at least 4 ms, so code 110 or higher.

Top module: `vstall_top`

## Requirements
- R1: After reset the register reads 0x0C. The supply select is 2'b10 (1.8 V), the CPU clock enable is 1 and busy is 0.
- R2: Register bits 7, 4 and 3 and the code field [2:0] are read/write. Bit 5 always reads 0, and bit 6 always reads its reset value 0; writes do not change either bit.
- R3: Stall codes 000 and 001 give 8 slow-clock periods. Codes 010 to 111 give 16, 32, 64, 128, 256 and 512 periods.
- R4: A request in the idle state with a level code of 2'b00 (1.1 V), 2'b01 (1.3 V) or 2'b10 (1.8 V) takes effect at the next clock edge. At that edge the supply select takes the requested level, and the CPU clock enable falls and busy rises. A request with level code 2'b11 is dropped.
- R5: The stall count advances only on cycles with the slow tick high. The CPU clock enable rises, and busy falls, at the clock edge that samples the last counted tick.
- R6: A supply-change request made while a stall is running is dropped. Neither the supply select nor the stall length changes.
- R7: With bit 4 set, a deep-mode entry strobe in the idle state sets the supply select to 2'b00 at the next edge. The CPU clock enable is then held low until wake-up.
- R8: With bit 4 clear, deep-mode entry leaves the supply select unchanged. The following wake-up raises the CPU clock enable at the next edge, with no stall.
- R9: Wake-up from an entry that lowered the supply restores the previous level at the next edge. The CPU is then held for the programmed stall length.
- R10: The peripheral clock enable output is always 1.
- R11: In the idle state a supply-change request wins over a simultaneous deep-mode entry. A wake-up strobe while not asleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| chg_req | input | 1 | Supply-change request strobe |
| chg_level | input | 2 | Requested supply level code |
| deep_enter | input | 1 | Deep low-power mode entry strobe |
| deep_wake | input | 1 | Deep low-power mode wake-up strobe |
| supply_sel | output | 2 | Supply-level select to the regulator |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| busy | output | 1 | A stall is in progress |

## Verification
A wrong stall counter shows up as a CPU clock enable that rises one or more slow ticks early or late. The bench counts ticks to the edge for every code, so an error is visible within one slow period of the expected release. A lost or stale saved level shows on the supply select in the same clock edge as the wake-up. A sequencer that leaves the idle state by mistake pulls the CPU clock enable low on the next fast edge. A register bit that drops its value is read back on the next read.

// File: rtl/vstall_pkg.sv
package vstall_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        LV_1V1 = 2'b00,
        LV_1V3 = 2'b01,
        LV_1V8 = 2'b10,
        LV_BAD = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_SLEEP = 2'd2
    } seq_state_e;

    // Writable content of the control register
    typedef struct packed {
        logic              spare_hi;   // bit 7
        logic              deep_drop;  // bit 4
        logic              spare_lo;   // bit 3
        logic [CODE_W-1:0] code;       // bits 2:0
    } ctrl_s;

    // Log2 of the stall length: codes 0 and 1 share the shortest length
    function automatic int unsigned stall_log2(input logic [CODE_W-1:0] code,
                                               input int unsigned min_log2);
        int unsigned shift;
        shift = (code < 2) ? 0 : int'(code) - 1;
        return min_log2 + shift;
    endfunction

    function automatic bit level_ok(input logic [1:0] lv);
        return lv != LV_BAD;
    endfunction

endpackage

// File: rtl/vstall_reg.sv
module vstall_reg
    import vstall_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_VAL = 8'h0C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output ctrl_s            ctrl
);

    localparam ctrl_s RST_CTRL = '{spare_hi:  RST_VAL[7],
                                   deep_drop: RST_VAL[4],
                                   spare_lo:  RST_VAL[3],
                                   code:      RST_VAL[CODE_W-1:0]};
    localparam logic FIXED_B6 = RST_VAL[6];

    ctrl_s ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_CTRL;
        end else if (wr_en) begin
            ctrl_q.spare_hi  <= wdata[7];
            ctrl_q.deep_drop <= wdata[4];
            ctrl_q.spare_lo  <= wdata[3];
            ctrl_q.code      <= wdata[CODE_W-1:0];
        end
    end

    always_comb begin
        rdata = {ctrl_q.spare_hi, FIXED_B6, 1'b0, ctrl_q.deep_drop,
                 ctrl_q.spare_lo, ctrl_q.code};
    end

    assign ctrl = ctrl_q;

    // R2: content only moves on a write strobe
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

    // R2: a write lands in the next read
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rdata[4:0] == $past(wdata[4:0]) && rdata[7] == $past(wdata[7]));

endmodule

// File: rtl/vstall_timer.sv
module vstall_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             running,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign running = cnt_q != '0;
    assign done    = tick && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) && !load;

    // R5: without a tick or a load the count holds
    p_tick_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));

    // R5: a tick on a running count takes exactly one off
    p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/vstall_seq.sv
module vstall_seq
    import vstall_pkg::*;
#(
    parameter int     CNT_W     = 10,
    parameter int     MIN_LOG2  = 3,
    parameter level_e RST_LEVEL = LV_1V8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chg_req,
    input  logic [1:0]        chg_level,
    input  logic              deep_enter,
    input  logic              deep_wake,
    input  logic              deep_drop,
    input  logic [CODE_W-1:0] code,
    input  logic              done,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output level_e            level,
    output logic              cpu_en
);

    seq_state_e state_q, state_d;
    level_e     level_q, level_d;
    level_e     saved_q, saved_d;
    logic       lowered_q, lowered_d;

    logic accept_chg, accept_deep, accept_wake;

    always_comb begin
        accept_chg  = (state_q == ST_IDLE) && chg_req && level_ok(chg_level);
        accept_deep = (state_q == ST_IDLE) && deep_enter && !accept_chg;
        accept_wake = (state_q == ST_SLEEP) && deep_wake;
    end

    always_comb begin
        state_d   = state_q;
        level_d   = level_q;
        saved_d   = saved_q;
        lowered_d = lowered_q;
        load      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_chg) begin
                    level_d = level_e'(chg_level);
                    load    = 1'b1;
                    state_d = ST_STALL;
                end else if (accept_deep) begin
                    lowered_d = deep_drop;
                    state_d   = ST_SLEEP;
                    if (deep_drop) begin
                        saved_d = level_q;
                        level_d = LV_1V1;
                    end
                end
            end
            ST_STALL: begin
                if (done) state_d = ST_IDLE;
            end
            ST_SLEEP: begin
                if (accept_wake) begin
                    lowered_d = 1'b0;
                    if (lowered_q) begin
                        level_d = saved_q;
                        load    = 1'b1;
                        state_d = ST_STALL;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_val = '0;
        load_val[stall_log2(code, MIN_LOG2)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            level_q   <= RST_LEVEL;
            saved_q   <= RST_LEVEL;
            lowered_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            level_q   <= level_d;
            saved_q   <= saved_d;
            lowered_q <= lowered_d;
        end
    end

    assign level  = level_q;
    assign cpu_en = (state_q == ST_IDLE);

    // R6: requests during a stall leave the level alone
    p_drop_busy_req_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STALL && chg_req) |=> $stable(level_q));

    // R7: a dropping entry selects the lowest level
    p_deep_low_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && deep_enter && !chg_req && deep_drop) |=> level_q == LV_1V1);

    // R9: wake-up after a drop restores the saved level
    p_restore_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && deep_wake && lowered_q) |=> level_q == $past(saved_q));

    // R4: an invalid level code never reaches the select
    p_no_bad_level_r4: assert property (@(posedge clk) disable iff (rst)
        level_q != LV_BAD);

endmodule

// File: rtl/vstall_top.sv
module vstall_top
    import vstall_pkg::*;
#(
    parameter int               MIN_LOG2  = 3,
    parameter logic [REG_W-1:0] RST_VAL   = 8'h0C,
    parameter level_e           RST_LEVEL = LV_1V8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             slow_tick,
    input  logic             chg_req,
    input  logic [1:0]       chg_level,
    input  logic             deep_enter,
    input  logic             deep_wake,
    output logic [1:0]       supply_sel,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             busy
);

    localparam int MAX_LOG2 = MIN_LOG2 + (1 << CODE_W) - 2;
    localparam int CNT_W    = MAX_LOG2 + 1;

    ctrl_s            ctrl;
    logic             load, running, done;
    logic [CNT_W-1:0] load_val;
    level_e           level;

    vstall_reg #(.RST_VAL(RST_VAL)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    vstall_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .tick     (slow_tick),
        .running  (running),
        .done     (done)
    );

    vstall_seq #(
        .CNT_W     (CNT_W),
        .MIN_LOG2  (MIN_LOG2),
        .RST_LEVEL (RST_LEVEL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .chg_req    (chg_req),
        .chg_level  (chg_level),
        .deep_enter (deep_enter),
        .deep_wake  (deep_wake),
        .deep_drop  (ctrl.deep_drop),
        .code       (ctrl.code),
        .done       (done),
        .load       (load),
        .load_val   (load_val),
        .level      (level),
        .cpu_en     (cpu_clk_en)
    );

    assign supply_sel    = level;
    assign busy          = running;
    assign periph_clk_en = 1'b1;

    // R4: a running count always keeps the CPU held
    p_busy_holds_cpu_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> !cpu_clk_en);

    // R5: the CPU is released exactly when the count drains
    p_release_on_drain_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> cpu_clk_en);

endmodule

// File: tb/test_vstall_top.sv
module test_vstall_top;
    import vstall_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       slow_tick = 1'b0;
    logic       chg_req = 1'b0;
    logic [1:0] chg_level = 2'b00;
    logic       deep_enter = 1'b0;
    logic       deep_wake = 1'b0;
    logic [1:0] supply_sel;
    logic       cpu_clk_en, periph_clk_en, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int periph_drops = 0;

    always #4 clk = ~clk;

    vstall_top i_vstall_top (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .slow_tick(slow_tick), .chg_req(chg_req),
        .chg_level(chg_level), .deep_enter(deep_enter), .deep_wake(deep_wake),
        .supply_sel(supply_sel), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .busy(busy)
    );

    always @(negedge clk) if (!rst && periph_clk_en !== 1'b1) periph_drops++;

    // stall code and expected period count
    localparam logic [18:0] TAB [8] = '{
        {3'd0, 16'd8},   {3'd1, 16'd8},   {3'd2, 16'd16},  {3'd3, 16'd32},
        {3'd4, 16'd64},  {3'd5, 16'd128}, {3'd6, 16'd256}, {3'd7, 16'd512}
    };

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic tick();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic req(input logic [1:0] lv);
        chg_req = 1'b1; chg_level = lv;
        @(negedge clk);
        chg_req = 1'b0;
    endtask

    // ticks until the CPU clock enable rises
    task automatic count_stall(output int n);
        n = 0;
        while (cpu_clk_en == 1'b0 && n < 1000) begin
            tick();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(reg_rdata, 8'h0C, "R1 rdata");
        check(supply_sel, 2'b10, "R1 supply");
        check(cpu_clk_en, 1, "R1 cpu_en");
        check(busy, 0, "R1 busy");

        // R2 register access
        wr(8'hFF);
        check(reg_rdata, 8'h9F, "R2 write ones");
        wr(8'h00);
        check(reg_rdata, 8'h00, "R2 write zeros");

        // R3/R4/R5 table walk over every code
        for (int i = 0; i < 8; i++) begin
            logic [1:0] lv;
            lv = (i % 2 == 0) ? 2'b01 : 2'b10;
            wr({5'b0, TAB[i][18:16]});
            req(lv);
            check(supply_sel, lv, "R4 level taken");
            check(cpu_clk_en, 0, "R4 cpu held");
            check(busy, 1, "R4 busy");
            repeat (5) @(negedge clk);
            check(cpu_clk_en, 0, "R5 no tick no progress");
            count_stall(n);
            check(n[15:0], TAB[i][15:0], "R3 stall length");
            check(busy, 0, "R5 busy released");
        end

        // R4 invalid level dropped
        req(2'b11);
        check(cpu_clk_en, 1, "R4 bad level no stall");
        check(supply_sel, 2'b10, "R4 bad level supply");

        // R6 request during stall dropped
        wr(8'h00);
        req(2'b00);
        repeat (3) tick();
        req(2'b01);
        check(supply_sel, 2'b00, "R6 supply unchanged");
        count_stall(n);
        check(n[15:0], 16'd5, "R6 stall length unchanged");

        // R7/R9 deep entry with drop (code 011 -> 32)
        req(2'b01);
        count_stall(n);
        wr(8'h13);
        deep_enter = 1'b1; @(negedge clk); deep_enter = 1'b0;
        check(supply_sel, 2'b00, "R7 lowered");
        check(cpu_clk_en, 0, "R7 cpu held asleep");
        repeat (40) tick();
        check(cpu_clk_en, 0, "R7 asleep through ticks");
        deep_wake = 1'b1; @(negedge clk); deep_wake = 1'b0;
        check(supply_sel, 2'b01, "R9 restored");
        check(cpu_clk_en, 0, "R9 held after wake");
        count_stall(n);
        check(n[15:0], 16'd32, "R9 wake stall length");

        // R8 deep entry without drop
        wr(8'h03);
        deep_enter = 1'b1; @(negedge clk); deep_enter = 1'b0;
        check(supply_sel, 2'b01, "R8 supply kept");
        check(cpu_clk_en, 0, "R8 asleep");
        deep_wake = 1'b1; @(negedge clk); deep_wake = 1'b0;
        check(cpu_clk_en, 1, "R8 immediate wake");
        check(busy, 0, "R8 no stall");

        // R11 priority and stray wake
        wr(8'h10);
        chg_req = 1'b1; chg_level = 2'b10; deep_enter = 1'b1;
        @(negedge clk);
        chg_req = 1'b0; deep_enter = 1'b0;
        check(supply_sel, 2'b10, "R11 change wins");
        check(busy, 1, "R11 stalling not asleep");
        count_stall(n);
        check(n[15:0], 16'd8, "R11 stall length");
        deep_wake = 1'b1; @(negedge clk); deep_wake = 1'b0;
        check(cpu_clk_en, 1, "R11 stray wake");
        check(supply_sel, 2'b10, "R11 stray wake supply");

        // R10 peripheral enable never dropped
        check(periph_drops[15:0], 16'd0, "R10 periph drops");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule